// File: doc/BRIEF.md
# Interrupt-Capable Character Input/Output Port

This block sits on a simple synchronous processor bus and gives software a four-byte window onto a character terminal: one byte arriving from a keyboard, one byte leaving for a display, a status byte and a control byte. The keyboard side presents a byte together with a one-cycle strobe. The block latches that byte and raises an input-ready flag. Software reads the byte, and the read clears the flag. On the display side, a byte that software writes appears on the display data pins and clears an output-ready flag. A one-cycle ready pulse from the display sets the flag again.

A control bit lets software choose between polling and interrupts. While that bit is set and an input byte is waiting, the block pulls its active-low request output down. The output is meant for an open-drain request line shared with other devices. When the block does not request, it releases the line, which is modelled here as a logic 1. A keyboard byte that arrives before the previous one was read replaces it and sets a sticky overrun flag.

Top module: `char_io_port`

## Requirements
- R1: After synchronous reset, input-ready is 0, output-ready is 1, overrun is 0, the interrupt enable is 0, `irq_n` is 1, `bus_rdata` is 0 and `disp_data` is 0.
- R2: The byte offsets are 0 for input data (read), 1 for output data (read returns the last byte written), 2 for status and 3 for control. A read presents its data on `bus_rdata` at the clock edge that accepts the access, and the value holds until the next read.
- R3: A cycle with `kbd_strobe` high loads `kbd_data` into the input data register and sets input-ready (status bit 0).
- R4: A read at offset 0 clears input-ready. If a keyboard strobe arrives in the same cycle, the strobe wins: the flag stays 1 and the new byte is held.
- R5: A strobe while input-ready is 1, with no offset-0 read in the same cycle, overwrites the data and sets overrun (status bit 7). Overrun stays set until a read at offset 2, and that read still returns it as 1.
- R6: A write at offset 1 drives `disp_data` with the written byte and clears output-ready (status bit 1). A `disp_ready` pulse sets output-ready. If the write and the pulse fall in the same cycle, the write wins.
- R7: Control bit 2 is the interrupt enable and is the only control bit that can be written. All other control bits read as 0. Writes at offsets 0 and 2 change nothing.
- R8: `irq_n` is 0 exactly while the interrupt enable and input-ready are both 1. It changes in the same cycle as those flags.
- R9: Status bits 2 to 6 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Byte offset within the port |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| kbd_strobe | input | 1 | One-cycle pulse: new keyboard byte |
| kbd_data | input | DATA_W | Keyboard byte |
| disp_ready | input | 1 | One-cycle pulse: display can take a byte |
| disp_data | output | DATA_W | Byte for the display |
| irq_n | output | 1 | Active-low request for the shared open-drain line (1 = released) |

## Verification
The hardest situations to reach are the same-cycle collisions: a keyboard strobe landing in the exact cycle that software reads the input byte, and a display-ready pulse coinciding with an output write. Ordinary bus tasks never line these up. The bench therefore drives both sides on the same falling edge, so both events are sampled at a single rising edge. It then checks which side won through the status byte, the read data and `irq_n`. Overrun is reached by two strobes with no read between them, followed by two status reads that show the flag being reported once and then cleared.

// File: rtl/charif_pkg.sv
package charif_pkg;
  // register offsets inside the four-byte window
  localparam int unsigned OFS_IN   = 0;
  localparam int unsigned OFS_OUT  = 1;
  localparam int unsigned OFS_STAT = 2;
  localparam int unsigned OFS_CTL  = 3;
  // bit positions decoded by software
  localparam int unsigned ST_RDY_IN  = 0;
  localparam int unsigned ST_RDY_OUT = 1;
  localparam int unsigned ST_OVR     = 7;
  localparam int unsigned CTL_IE     = 2;
  localparam int unsigned ADDR_W     = 2;
endpackage

// File: rtl/kbd_in_reg.sv
module kbd_in_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [DATA_W-1:0] kdata,
  input  logic              rd_take,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] data_q,
  output logic              ready_q,
  output logic              ready_d,
  output logic              ovr_q
);
  logic ovr_d;

  always_comb begin
    ready_d = ready_q;
    if (rd_take) ready_d = 1'b0;
    if (strobe)  ready_d = 1'b1;
    ovr_d = ovr_q;
    if (stat_rd) ovr_d = 1'b0;
    if (strobe && ready_q && !rd_take) ovr_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (strobe) data_q <= kdata;
      ready_q <= ready_d;
      ovr_q   <= ovr_d;
    end
  end

  // R3
  kbd_load_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (ready_q && data_q == $past(kdata)));
  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_take && !strobe) |=> !ready_q);
  // R5
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && ready_q && !rd_take) |=> ovr_q);
  // R5
  ovr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !stat_rd) |=> ovr_q);
endmodule

// File: rtl/disp_out_reg.sv
module disp_out_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ready_pulse,
  output logic [DATA_W-1:0] data_q,
  output logic              room_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      room_q <= 1'b1;
    end else begin
      if (wr) begin
        data_q <= wdata;
        room_q <= 1'b0;
      end else if (ready_pulse) begin
        room_q <= 1'b1;
      end
    end
  end

  // R6
  wr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> (!room_q && data_q == $past(wdata)));
  // R6
  rdy_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_pulse && !wr) |=> room_q);
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wbit,
  input  logic sin_d,
  input  logic sin_q,
  output logic ken_q,
  output logic irq_n_q
);
  logic ken_d;

  always_comb ken_d = wr ? wbit : ken_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ken_q   <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      ken_q   <= ken_d;
      irq_n_q <= ~(ken_d & sin_d);
    end
  end

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_n_q == !(ken_q && sin_q));
endmodule

// File: rtl/char_io_port.sv
module char_io_port
  import charif_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kbd_strobe,
  input  logic [DATA_W-1:0] kbd_data,
  input  logic              disp_ready,
  output logic [DATA_W-1:0] disp_data,
  output logic              irq_n
);
  logic rd, wr, rd_in, rd_stat, wr_out, wr_ctl;
  logic [DATA_W-1:0] in_data, rd_next, stat_v, ctl_v;
  logic sin_q, sin_d, ovr_q, sout_q, ken_q;

  assign rd      = bus_sel && !bus_we;
  assign wr      = bus_sel && bus_we;
  assign rd_in   = rd && bus_addr == ADDR_W'(OFS_IN);
  assign rd_stat = rd && bus_addr == ADDR_W'(OFS_STAT);
  assign wr_out  = wr && bus_addr == ADDR_W'(OFS_OUT);
  assign wr_ctl  = wr && bus_addr == ADDR_W'(OFS_CTL);

  kbd_in_reg #(.DATA_W(DATA_W)) in_i (
    .clk(clk), .rst(rst), .strobe(kbd_strobe), .kdata(kbd_data),
    .rd_take(rd_in), .stat_rd(rd_stat), .data_q(in_data),
    .ready_q(sin_q), .ready_d(sin_d), .ovr_q(ovr_q));

  disp_out_reg #(.DATA_W(DATA_W)) out_i (
    .clk(clk), .rst(rst), .wr(wr_out), .wdata(bus_wdata),
    .ready_pulse(disp_ready), .data_q(disp_data), .room_q(sout_q));

  irq_ctl ctl_i (
    .clk(clk), .rst(rst), .wr(wr_ctl), .wbit(bus_wdata[CTL_IE]),
    .sin_d(sin_d), .sin_q(sin_q), .ken_q(ken_q), .irq_n_q(irq_n));

  always_comb begin
    stat_v = '0;
    stat_v[ST_RDY_IN]  = sin_q;
    stat_v[ST_RDY_OUT] = sout_q;
    stat_v[ST_OVR]     = ovr_q;
    ctl_v = '0;
    ctl_v[CTL_IE] = ken_q;
    unique case (bus_addr)
      ADDR_W'(OFS_IN):   rd_next = in_data;
      ADDR_W'(OFS_OUT):  rd_next = disp_data;
      ADDR_W'(OFS_STAT): rd_next = stat_v;
      default:           rd_next = ctl_v;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_next;
  end

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(bus_rdata));
endmodule

// File: tb/char_io_port_tb_top.sv
module char_io_port_tb_top;
  logic clk = 0, rst = 1;
  logic bus_sel = 0, bus_we = 0, kbd_strobe = 0, disp_ready = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, kbd_data = 0;
  logic [7:0] bus_rdata, disp_data;
  logic irq_n;
  int checks = 0, failures = 0;
  logic sout_m = 1, ken_m = 0;
  logic [7:0] r;

  always #10 clk = ~clk;

  char_io_port #(.DATA_W(8)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kbd_strobe(kbd_strobe), .kbd_data(kbd_data), .disp_ready(disp_ready),
    .disp_data(disp_data), .irq_n(irq_n));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic kbd(input logic [7:0] d);
    @(negedge clk); kbd_strobe = 1; kbd_data = d;
    @(negedge clk); kbd_strobe = 0;
  endtask

  function automatic logic [7:0] stat(input logic sin, input logic sout, input logic ovr);
    return {ovr, 5'b0, sout, sin};
  endfunction

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
    chk("R1 rdata", bus_rdata, 8'h00);
    chk("R1 disp_data", disp_data, 8'h00);
    rd(2'd2, r); chk("R1 status", r, stat(0, 1, 0));
    rd(2'd3, r); chk("R1 ctl", r, 8'h00);

    // sweep every byte value through all paths
    for (int v = 0; v < 256; v++) begin
      wr(2'd3, 8'(v)); ken_m = v[2];
      rd(2'd3, r); chk("R7 ctl readback", r, {5'b0, ken_m, 2'b0});
      kbd(8'(v));
      chk("R8 irq after strobe", {7'b0, irq_n}, {7'b0, !ken_m});
      rd(2'd2, r); chk("R3 R9 status after strobe", r, stat(1, sout_m, 0));
      rd(2'd0, r); chk("R3 R2 input data", r, 8'(v));
      chk("R8 irq after read", {7'b0, irq_n}, 8'h01);
      rd(2'd2, r); chk("R4 status after read", r, stat(0, sout_m, 0));
      wr(2'd1, 8'(v ^ 8'hA5)); sout_m = 0;
      chk("R6 disp_data", disp_data, 8'(v ^ 8'hA5));
      rd(2'd1, r); chk("R2 out readback", r, 8'(v ^ 8'hA5));
      rd(2'd2, r); chk("R6 sout cleared", r, stat(0, 0, 0));
      @(negedge clk); disp_ready = 1; @(negedge clk); disp_ready = 0; sout_m = 1;
      rd(2'd2, r); chk("R6 sout set", r, stat(0, 1, 0));
    end

    // R5 overrun
    wr(2'd3, 8'h04);
    kbd(8'h11); kbd(8'h22);
    rd(2'd2, r); chk("R5 overrun reported", r, stat(1, 1, 1));
    rd(2'd2, r); chk("R5 overrun cleared by status read", r, stat(1, 1, 0));
    rd(2'd0, r); chk("R5 overwritten data", r, 8'h22);

    // R4 collision: read input and strobe in same cycle
    kbd(8'h33);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = 2'd0; kbd_strobe = 1; kbd_data = 8'h44;
    @(negedge clk); bus_sel = 0; kbd_strobe = 0;
    chk("R4 collision read returns old", bus_rdata, 8'h33);
    chk("R8 collision irq held", {7'b0, irq_n}, 8'h00);
    rd(2'd2, r); chk("R4 R5 collision status", r, stat(1, 1, 0));
    rd(2'd0, r); chk("R4 collision new data", r, 8'h44);

    // R7 writes to offsets 0 and 2 ignored
    kbd(8'h5A);
    wr(2'd0, 8'hFF); wr(2'd2, 8'hFF);
    rd(2'd2, r); chk("R7 status write ignored", r, stat(1, 1, 0));
    rd(2'd0, r); chk("R7 input write ignored", r, 8'h5A);

    // R6 collision: write and ready pulse same cycle
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = 2'd1; bus_wdata = 8'h77; disp_ready = 1;
    @(negedge clk); bus_sel = 0; bus_we = 0; disp_ready = 0;
    rd(2'd2, r); chk("R6 write beats ready", r, stat(0, 0, 0));
    chk("R6 collision data", disp_data, 8'h77);

    // R8 disable with pending input
    kbd(8'h01);
    chk("R8 enabled pending", {7'b0, irq_n}, 8'h00);
    wr(2'd3, 8'h00);
    chk("R8 disabled pending", {7'b0, irq_n}, 8'h01);
    finish_run();
  end
endmodule